// File: doc/BRIEF.md
# Clock Source Task-Event Controller

This block sequences three clock sources (a crystal oscillator, a PLL and a low-frequency clock) and two background jobs (an RC calibration run and a crystal tuning run). Each source responds to single-cycle start and stop strobes. A source is started only when it is off, it settles after a per-source cycle count, and it is stopped at once. Each job runs for its own cycle count and then reports completion.

The outcome of each sequence is a sticky event flag. A run bit per source shows that a start request is in force. A settled bit per source shows that the clock is usable. An enable mask selects which events drive a level interrupt, and a pending view shows exactly the events that drive the line. The low-frequency source selection is captured when that clock is started and is reported with its settled status. Software reads all state through a combinational read port. It clears events and edits the enable mask through a simple write port.

Top module: `clkctl_top`

## Requirements
- R1: After a synchronous reset every source is off (state code 0), and event, enable, run, settled, copy and warning storage read 0. `irq` is low.
- R2: A start strobe is taken only when the source is off (code 0) or stopping (code 3). It moves the source to starting (code 1) and loads its settle count. In starting (1) or running (2) a start strobe has no effect and does not reload the count.
- R3: A stop strobe is taken only in starting or running. The source returns to off within that one edge, and its run and settled bits clear. A stop taken in starting prevents the completion. A stop in off has no effect.
- R4: The run bit of a source is set on the edge that takes a start. It stays set through completion until a stop is taken.
- R5: A source in starting completes on the N-th edge after the start was taken, N being its delay parameter. At that edge it enters running (code 2), sets its settled bit and raises its own event: bit 0 crystal, bit 1 PLL, bit 2 low-frequency.
- R6: Crystal completion also raises the tuned event (bit 4) on the same edge.
- R7: Taking a low-frequency start copies `lf_src_sel` into the copy register. The STAT source field (bits 4 and up) shows that copy while the low-frequency clock is settled and shows 0 otherwise. Later changes of `lf_src_sel` do not alter the copy.
- R8: Calibration and tuning requests are taken only when the job is idle. A taken job finishes after its delay parameter in edges and raises the done event (bit 3, calibration) or the tuned event (bit 4, tuning). A request made while the job is busy is dropped.
- R9: `irq` is high exactly when some event bit and its enable bit are both set. PEND shows that AND. Writing 1s to ENSET sets enable bits, and writing 1s to ENCLR clears them. Both addresses read back the mask.
- R10: A calibration request taken while the crystal is not running sets a sticky warning (AUX bit 8) that only reset clears.
- R11: A write to EVT clears each event whose data bit is 0 and keeps those whose bit is 1. An event raised on the same edge survives the clear. Completions on the same edge are all recorded.
- R12: The register map is EVT=0, ENSET=1, ENCLR=2, PEND=3, RUN=4 (bit i per source), STAT=5 (settled bits 0..2, source field from bit 4), AUX=6 (copy in low bits, warning bit 8), STATE=7 (2-bit state code per source, source i at bits 2i+1:2i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_start | input | 3 | Start strobes, bit 0 crystal, 1 PLL, 2 low-frequency |
| task_stop | input | 3 | Stop strobes, same bit order |
| task_cal | input | 1 | Calibration request strobe |
| task_tune | input | 1 | Crystal tuning request strobe |
| lf_src_sel | input | SRC_W | Low-frequency source selection |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 5 | Write data, one bit per event |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with settle delays of 3, 3 and 5 cycles for the three sources and 2 cycles for each job. Delays above one make the starting state last long enough for a stop or a repeated start to land inside it. Equal crystal and PLL delays give exactly coincident completions. A tuning request placed one cycle after a crystal start finishes on the same edge as the crystal, so both paths drive the tuned event at once.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned NSRC   = 3;
    localparam int unsigned NEVT   = 5;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 32;

    localparam int unsigned SRC_XO  = 0;
    localparam int unsigned SRC_PLL = 1;
    localparam int unsigned SRC_LF  = 2;

    localparam int unsigned EV_XO    = 0;
    localparam int unsigned EV_PLL   = 1;
    localparam int unsigned EV_LF    = 2;
    localparam int unsigned EV_CAL   = 3;
    localparam int unsigned EV_TUNED = 4;

    localparam int unsigned STAT_SRC_LSB = 4;
    localparam int unsigned WARN_BIT     = 8;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_STARTING = 2'd1,
        ST_ON       = 2'd2,
        ST_STOPPING = 2'd3
    } src_state_e;

    typedef enum logic [ADDR_W-1:0] {
        A_EVT   = 3'd0,
        A_ENSET = 3'd1,
        A_ENCLR = 3'd2,
        A_PEND  = 3'd3,
        A_RUN   = 3'd4,
        A_STAT  = 3'd5,
        A_AUX   = 3'd6,
        A_STATE = 3'd7
    } reg_addr_e;

    function automatic logic can_start(src_state_e s);
        return (s == ST_OFF) || (s == ST_STOPPING);
    endfunction

    function automatic logic can_stop(src_state_e s);
        return (s == ST_ON) || (s == ST_STARTING);
    endfunction

endpackage

// File: rtl/clkctl_src_seq.sv
module clkctl_src_seq import clkctl_pkg::*; #(
    parameter int unsigned DLY = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    output src_state_e state_o,
    output logic       run_o,
    output logic       stat_o,
    output logic       done_o
);
    localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    src_state_e    st_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, stat_q;
    logic          start_ok, stop_ok;

    always_comb begin
        start_ok = start_i && can_start(st_q);
        stop_ok  = stop_i && can_stop(st_q);
        done_o   = (st_q == ST_STARTING) && (cnt_q == '0) && !stop_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            stat_q <= 1'b0;
        end else if (start_ok) begin
            st_q  <= ST_STARTING;
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (stop_ok) begin
            // passes through stopping and lands in off on the same edge
            st_q   <= ST_OFF;
            run_q  <= 1'b0;
            stat_q <= 1'b0;
        end else if (done_o) begin
            st_q   <= ST_ON;
            stat_q <= 1'b1;
        end else if (st_q == ST_STARTING) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign state_o = st_q;
    assign run_o   = run_q;
    assign stat_o  = stat_q;

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON && !stop_i) |=> (st_q == ST_ON));
    assert_stop_immediate_R3: assert property (@(posedge clk) disable iff (rst)
        (stop_i && can_stop(st_q)) |=> (st_q == ST_OFF && !run_q && !stat_q));
    assert_run_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        run_q == (st_q != ST_OFF));
    assert_done_settles_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (st_q == ST_ON && stat_q && run_q));
endmodule

// File: rtl/clkctl_job.sv
module clkctl_job #(
    parameter int unsigned DLY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign done_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_job_finishes_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_q);
    assert_job_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_o) |=> busy_q);
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top import clkctl_pkg::*; #(
    parameter int unsigned XO_DLY   = 1,
    parameter int unsigned PLL_DLY  = 1,
    parameter int unsigned LF_DLY   = 1,
    parameter int unsigned CAL_DLY  = 1,
    parameter int unsigned TUNE_DLY = 1,
    parameter int unsigned SRC_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   task_start,
    input  logic [NSRC-1:0]   task_stop,
    input  logic              task_cal,
    input  logic              task_tune,
    input  logic [SRC_W-1:0]  lf_src_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NEVT-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int unsigned SRC_DLY [NSRC] = '{XO_DLY, PLL_DLY, LF_DLY};

    src_state_e       st [NSRC];
    logic [NSRC-1:0]  run, stat, done;
    logic             cal_busy, cal_done, tune_busy, tune_done;
    logic             cal_go, lf_take;
    logic [NEVT-1:0]  evt_q, en_q, ev_set, pend;
    logic [SRC_W-1:0] copy_q, lfsrc_q;
    logic             warn_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        clkctl_src_seq #(.DLY(SRC_DLY[g])) u_seq (
            .clk     (clk),
            .rst     (rst),
            .start_i (task_start[g]),
            .stop_i  (task_stop[g]),
            .state_o (st[g]),
            .run_o   (run[g]),
            .stat_o  (stat[g]),
            .done_o  (done[g])
        );
    end

    clkctl_job #(.DLY(CAL_DLY)) u_cal (
        .clk(clk), .rst(rst), .go_i(task_cal), .busy_o(cal_busy), .done_o(cal_done)
    );
    clkctl_job #(.DLY(TUNE_DLY)) u_tune (
        .clk(clk), .rst(rst), .go_i(task_tune), .busy_o(tune_busy), .done_o(tune_done)
    );

    always_comb begin
        cal_go  = task_cal && !cal_busy;
        lf_take = task_start[SRC_LF] && can_start(st[SRC_LF]);
        ev_set            = '0;
        ev_set[EV_XO]     = done[SRC_XO];
        ev_set[EV_PLL]    = done[SRC_PLL];
        ev_set[EV_LF]     = done[SRC_LF];
        ev_set[EV_CAL]    = cal_done;
        ev_set[EV_TUNED]  = done[SRC_XO] | tune_done;
        pend              = evt_q & en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q   <= '0;
            en_q    <= '0;
            copy_q  <= '0;
            lfsrc_q <= '0;
            warn_q  <= 1'b0;
        end else begin
            evt_q <= ((wr_en && wr_addr == A_EVT) ? (evt_q & wr_data) : evt_q) | ev_set;
            if (wr_en && wr_addr == A_ENSET) en_q <= en_q | wr_data;
            else if (wr_en && wr_addr == A_ENCLR) en_q <= en_q & ~wr_data;
            if (lf_take) copy_q <= lf_src_sel;
            if (done[SRC_LF]) lfsrc_q <= copy_q;
            if (cal_go && st[SRC_XO] != ST_ON) warn_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EVT:   rd_data[NEVT-1:0] = evt_q;
            A_ENSET: rd_data[NEVT-1:0] = en_q;
            A_ENCLR: rd_data[NEVT-1:0] = en_q;
            A_PEND:  rd_data[NEVT-1:0] = pend;
            A_RUN:   rd_data[NSRC-1:0] = run;
            A_STAT: begin
                rd_data[NSRC-1:0] = stat;
                rd_data[STAT_SRC_LSB +: SRC_W] = stat[SRC_LF] ? lfsrc_q : '0;
            end
            A_AUX: begin
                rd_data[SRC_W-1:0] = copy_q;
                rd_data[WARN_BIT]  = warn_q;
            end
            default: begin
                for (int i = 0; i < NSRC; i++) rd_data[2*i +: 2] = st[i];
            end
        endcase
    end

    assign irq = |pend;

    assert_xo_tuned_R6: assert property (@(posedge clk) disable iff (rst)
        done[SRC_XO] |=> (evt_q[EV_XO] && evt_q[EV_TUNED]));
    assert_copy_held_R7: assert property (@(posedge clk) disable iff (rst)
        !lf_take |=> $stable(copy_q));
    assert_warn_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        warn_q |=> warn_q);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (|ev_set) |=> ((evt_q & $past(ev_set)) == $past(ev_set)));
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (done[SRC_XO] && en_q[EV_XO] && !(wr_en && (wr_addr == A_ENCLR))) |=> irq);
endmodule

// File: tb/clkctl_top_tb_top.sv
`timescale 1ns/1ps
module clkctl_top_tb_top;
    localparam int XO_D = 3, PLL_D = 3, LF_D = 5, CAL_D = 2, TUNE_D = 2, SW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ts = '0, tp = '0;
    logic tcal = 1'b0, ttune = 1'b0;
    logic [SW-1:0] sel = '0;
    logic wen = 1'b0;
    logic [2:0] waddr = '0;
    logic [4:0] wdata = '0;
    logic [2:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic irq;

    always #2.5 clk = ~clk;

    clkctl_top #(.XO_DLY(XO_D), .PLL_DLY(PLL_D), .LF_DLY(LF_D), .CAL_DLY(CAL_D),
                 .TUNE_DLY(TUNE_D), .SRC_W(SW)) dut_i (
        .clk(clk), .rst(rst), .task_start(ts), .task_stop(tp), .task_cal(tcal),
        .task_tune(ttune), .lf_src_sel(sel), .wr_en(wen), .wr_addr(waddr),
        .wr_data(wdata), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    int n_chk = 0, n_bad = 0;
    bit finished = 0, cmp_on = 0, force_on = 0;
    logic [2:0] force_addr = '0;

    // behavioural reference model
    int m_st[3], m_cnt[3], m_dly[3];
    int m_run, m_stat, m_evt, m_en, m_copy, m_lfsrc, m_warn;
    int c_busy, c_cnt, t_busy, t_cnt;
    initial begin m_dly[0] = XO_D; m_dly[1] = PLL_D; m_dly[2] = LF_D; end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_evt;
            1, 2: return m_en;
            3: return m_evt & m_en;
            4: return m_run;
            5: return m_stat | (((m_stat >> 2) & 1) != 0 ? (m_lfsrc << 4) : 0);
            6: return m_copy | (m_warn << 8);
            default: return m_st[0] | (m_st[1] << 2) | (m_st[2] << 4);
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R5/R6/R11";
            1, 2: return "R9/R12";
            3: return "R9";
            4: return "R4";
            5: return "R5/R7";
            6: return "R7/R10";
            default: return "R2/R3";
        endcase
    endfunction

    always @(posedge clk) begin
        rd_addr <= force_on ? force_addr : rd_addr + 3'd1;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
            m_run = 0; m_stat = 0; m_evt = 0; m_en = 0; m_copy = 0; m_lfsrc = 0; m_warn = 0;
            c_busy = 0; c_cnt = 0; t_busy = 0; t_cnt = 0;
            cmp_on = 1;
        end else begin
            int setv;
            bit dn[3];
            setv = 0;
            for (int i = 0; i < 3; i++) begin
                bit go_ok, halt_ok;
                go_ok   = ts[i] && (m_st[i] == 0 || m_st[i] == 3);
                halt_ok = tp[i] && (m_st[i] == 1 || m_st[i] == 2);
                dn[i]   = (m_st[i] == 1) && (m_cnt[i] == 0) && !halt_ok;
                if (go_ok) begin
                    m_st[i] = 1; m_cnt[i] = m_dly[i] - 1; m_run |= (1 << i);
                    if (i == 2) m_copy = sel;
                end else if (halt_ok) begin
                    m_st[i] = 0; m_run &= ~(1 << i); m_stat &= ~(1 << i);
                end else if (dn[i]) begin
                    m_st[i] = 2; m_stat |= (1 << i); setv |= (1 << i);
                    if (i == 0) setv |= 16;
                    if (i == 2) m_lfsrc = m_copy;
                end else if (m_st[i] == 1) m_cnt[i]--;
            end
            if (tcal && c_busy == 0) begin
                if (!(m_st[0] == 2 && !dn[0]) && !(dn[0] == 0 && m_st[0] == 2)) m_warn = m_warn;
                c_busy = 1; c_cnt = CAL_D - 1;
            end else if (c_busy == 1 && c_cnt == 0) begin
                c_busy = 0; setv |= 8;
            end else if (c_busy == 1) c_cnt--;
            if (ttune && t_busy == 0) begin
                t_busy = 1; t_cnt = TUNE_D - 1;
            end else if (t_busy == 1 && t_cnt == 0) begin
                t_busy = 0; setv |= 16;
            end else if (t_busy == 1) t_cnt--;
            if (wen && waddr == 0) m_evt &= wdata;
            m_evt |= setv;
            if (wen && waddr == 1) m_en |= wdata;
            else if (wen && waddr == 2) m_en &= ~wdata;
        end
    end

    // warning depends on the crystal state before the edge: tracked separately
    int xo_prev = 0;
    always @(posedge clk) begin
        if (rst) xo_prev <= 0;
        else xo_prev <= m_st[0];
    end
    bit cal_busy_prev = 0;
    always @(posedge clk) begin
        if (!rst && tcal && !cal_busy_prev && xo_prev != 2) m_warn = 1;
        cal_busy_prev <= rst ? 1'b0 : (c_busy == 1);
    end

    always @(negedge clk) begin
        if (cmp_on && !rst && !finished) begin
            check({31'b0, irq}, ((m_evt & m_en) != 0) ? 32'd1 : 32'd0, "R9");
            check(rd_data, 32'(model_read(int'(rd_addr))), tag_of(int'(rd_addr)));
        end
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic idle_in();
        ts = '0; tp = '0; tcal = 0; ttune = 0; wen = 0; waddr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [4:0] d);
        wen = 1; waddr = a; wdata = d; step(); idle_in();
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string tag);
        force_addr = a; force_on = 1;
        step();
        check(rd_data & mask, exp, tag);
        force_on = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        idle_in();
        step(3);
        rst = 0;
        // R1: reset state
        peek(7, 32'hFFFF_FFFF, 0, "R1");
        peek(0, 32'hFFFF_FFFF, 0, "R1");
        check({31'b0, irq}, 0, "R1");
        wr(1, 5'h1F);
        // R4: run set on accepting edge
        ts = 3'b001; step(); idle_in();
        peek(4, 1, 1, "R4");
        // R2: a second start while starting does not reload the count
        ts = 3'b001; step(); idle_in();
        peek(0, 32'h11, 32'h11, "R2 R6");
        peek(5, 1, 1, "R5");
        check({31'b0, irq}, 1, "R9");
        // R8: calibration with crystal running, no warning
        tcal = 1; step(); idle_in();
        step(3);
        peek(0, 32'h08, 32'h08, "R8");
        peek(6, 32'h100, 0, "R10");
        // R3: immediate stop
        tp = 3'b001; step(); idle_in();
        peek(5, 1, 0, "R3");
        peek(4, 1, 0, "R3");
        peek(7, 3, 0, "R3");
        // R10: calibration with crystal off
        tcal = 1; step(); idle_in();
        step(3);
        peek(6, 32'h100, 32'h100, "R10");
        // R11: clear by writing zeros
        wr(0, 5'h00);
        peek(0, 32'h1F, 0, "R11");
        check({31'b0, irq}, 0, "R9");
        // R9: enable mask and pending view
        wr(2, 5'h1F);
        ts = 3'b010; step(); idle_in();
        step(4);
        peek(3, 32'h1F, 0, "R9");
        check({31'b0, irq}, 0, "R9");
        wr(1, 5'h02);
        peek(3, 32'h1F, 32'h02, "R9");
        check({31'b0, irq}, 1, "R9");
        // R7: source copy taken at start only
        sel = 2'd2; ts = 3'b100; step(); idle_in();
        sel = 2'd1;
        step(6);
        peek(6, 3, 2, "R7");
        peek(5, 32'h34, 32'h24, "R7");
        // R3: stop inside starting suppresses completion
        wr(0, 5'h00);
        tp = 3'b010; step(); idle_in();
        ts = 3'b010; step(); idle_in();
        tp = 3'b010; step(); idle_in();
        step(5);
        peek(7, 32'h0C, 0, "R3");
        peek(0, 32'h02, 0, "R3");
        // R11: coincident completions
        wr(1, 5'h1F);
        ts = 3'b011; step(); idle_in();
        ttune = 1; step(); idle_in();
        step(4);
        peek(0, 32'h13, 32'h13, "R11");
        // R11: set beats clear on the same edge
        wr(0, 5'h00);
        tp = 3'b001; step(); idle_in();
        ts = 3'b001; step(); idle_in();
        step(2);
        wen = 1; waddr = 0; wdata = 5'h00; step(); idle_in();
        peek(0, 1, 1, "R11");
        // pseudo-random traffic compared each cycle against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ts = (lfsr[3:0] == 0) ? lfsr[6:4] : 3'b0;
            tp = (lfsr[9:7] == 0) ? lfsr[12:10] : 3'b0;
            tcal = (lfsr[15:12] == 4'hF);
            ttune = (lfsr[11:8] == 4'h5);
            sel = lfsr[14:13];
            wen = (lfsr[7:5] == 3'd2);
            waddr = lfsr[2:0];
            wdata = lfsr[12:8];
            step();
        end
        idle_in();
        step(8);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule